// File: doc/BRIEF.md
# Ones-Complement Accumulator Execution Unit

This block is the arithmetic core of a small accumulator machine that keeps its numbers in ones-complement form. The 16-bit internal word has a sign bit at the top, an overflow bit just below it, and 14 data bits. Each cycle in which `op_valid` is high, the unit takes one instruction code and one memory operand. It updates the accumulator and may produce a word to write back to memory. It also returns a skip count from 0 to 3, which the surrounding sequencer adds to its program counter.

Memory words are 15 bits wide: a sign bit at bit 14 and 14 data bits. When an operand is read, its sign is copied into the overflow position to form the 16-bit internal value. When a word is stored, the top accumulator bit becomes the stored sign. The supported operations are a count-compare with a four-way skip, a store that corrects overflow, add, subtract, a complementing load, an exchange, and bitwise AND. Add and subtract keep overflow as a persistent accumulator state. A later store turns that state into a carry of +1 or -1 plus a skip.

All results are registered. They appear on the outputs in the cycle after the instruction is presented.

Top module: `oc_accum_unit`

## Requirements
- R1: After reset, `acc_out` is 0, and `res_valid`, `wr_en` and `skip_cnt` are 0.
- R2: An operand is widened by copying memory bit 14 (the sign) into accumulator bit 15. Accumulator bits 14:0 equal the memory bits 14:0.
- R3: Count-compare (code 0) loads a diminished absolute value. A positive operand x gives x-1. A negative operand gives (~x)-1. Plus zero and minus zero both give plus zero (all bits clear).
- R4: The count-compare skip comes from the widened operand before the diminish step. A value greater than zero gives 0, plus zero gives 1, a value less than zero gives 2, and minus zero (all ones) gives 3.
- R5: Store (code 1) with accumulator bits 15 and 14 equal writes accumulator bits 14:0 to memory. The accumulator is left unchanged and the skip is 0.
- R6: Store with bits 15 and 14 different writes {bit 15, bits 13:0}. The accumulator becomes +1 (0x0001) if bit 15 is 0, and -1 (0xFFFE) if bit 15 is 1. The skip is 1.
- R7: Add (code 2) and subtract (code 3) form the ones-complement sum with end-around carry (subtract adds the complemented operand). The full 16-bit result is kept, including any overflow state.
- R8: Complementing load (code 4) loads the bitwise complement of the widened operand. AND (code 6) loads the widened operand ANDed with the accumulator.
- R9: Exchange (code 5) loads the widened operand. If `mem_ro` is 0, it writes {old bit 15, old bits 13:0} to memory. If `mem_ro` is 1, it makes no write.
- R10: Results appear one clock after `op_valid`, with `res_valid` high for that one cycle. Code 7 leaves the accumulator unchanged and makes no write. In a cycle without `op_valid`, the next cycle shows `res_valid`, `wr_en` and `skip_cnt` at 0 and the accumulator held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 3 | Instruction code (0 to 7) |
| mem_rdata | input | 15 | Memory operand: sign at bit 14, data at bits 13:0 |
| mem_ro | input | 1 | Operand location is read-only |
| acc_out | output | 16 | Accumulator |
| wr_data | output | 15 | Word to write back to memory |
| wr_en | output | 1 | Write back `wr_data` this cycle |
| skip_cnt | output | 2 | Instructions to skip |
| res_valid | output | 1 | Outputs hold the result of an instruction |

## Verification
The bench builds the unit at its default 16-bit width, so the real word format is exercised. That includes the two-zero encodings and both overflow polarities, which it reaches by adding two near-full-scale operands of the same sign before a store. Directed sequences cover each count-compare class, both store outcomes and both exchange targets. A long random stream of all eight codes then runs against a behavioural model, which lets overflow states build up and decay across add, subtract and store.

// File: rtl/oc_pkg.sv
package oc_pkg;
    typedef enum logic [2:0] {
        OP_CNTCMP  = 3'd0,
        OP_STORE   = 3'd1,
        OP_ADD     = 3'd2,
        OP_SUB     = 3'd3,
        OP_NEGLOAD = 3'd4,
        OP_SWAP    = 3'd5,
        OP_AND     = 3'd6,
        OP_NOP     = 3'd7
    } op_e;

    localparam int SKIP_W = 2;
endpackage

// File: rtl/oc_eac_adder.sv
module oc_eac_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        // carry out of the top bit folds back into bit 0
        sum = raw[WIDTH-1:0] + {{(WIDTH-1){1'b0}}, raw[WIDTH]};
    end
endmodule

// File: rtl/oc_cntcmp.sv
module oc_cntcmp #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd,
    output logic [WIDTH-1:0] dim,
    output logic [1:0]       skip
);
    localparam logic [WIDTH-1:0] ONES = '1;
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb begin
        if (opnd == '0) begin
            dim  = '0;
            skip = 2'd1;
        end else if (opnd == ONES) begin
            dim  = '0;
            skip = 2'd3;
        end else if (!opnd[WIDTH-1]) begin
            dim  = opnd - ONE;
            skip = 2'd0;
        end else begin
            dim  = ~opnd - ONE;
            skip = 2'd2;
        end
    end
endmodule

// File: rtl/oc_store_fix.sv
module oc_store_fix #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] acc,
    output logic [WIDTH-2:0] wword,
    output logic [WIDTH-1:0] acc_fix,
    output logic             ovf
);
    localparam int TOP = WIDTH - 1;
    localparam int OVB = WIDTH - 2;

    always_comb begin
        ovf   = acc[TOP] ^ acc[OVB];
        // top bit always becomes the stored sign; equals bit OVB when no overflow
        wword = {acc[TOP], acc[OVB-1:0]};
        if (!ovf)
            acc_fix = acc;
        else if (acc[TOP])
            acc_fix = {{(WIDTH-1){1'b1}}, 1'b0};
        else
            acc_fix = {{(WIDTH-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/oc_accum_unit.sv
module oc_accum_unit
    import oc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WIDTH-2:0]  mem_rdata,
    input  logic              mem_ro,
    output logic [WIDTH-1:0]  acc_out,
    output logic [WIDTH-2:0]  wr_data,
    output logic              wr_en,
    output logic [SKIP_W-1:0] skip_cnt,
    output logic              res_valid
);
    localparam int MW = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0]  acc;
        logic [MW-1:0]     wdata;
        logic              we;
        logic [SKIP_W-1:0] skip;
        logic              vld;
    } state_t;

    state_t st_q, st_d;

    logic [WIDTH-1:0]  opnd_d;
    logic [WIDTH-1:0]  add_d, sub_d, dim_d, fix_d;
    logic [MW-1:0]     stw_d;
    logic [1:0]        ccs_skip_d;
    logic              ovf_d;

    assign opnd_d = {mem_rdata[MW-1], mem_rdata};

    oc_eac_adder #(.WIDTH(WIDTH)) u_add (
        .a(st_q.acc), .b(opnd_d), .sum(add_d)
    );
    oc_eac_adder #(.WIDTH(WIDTH)) u_sub (
        .a(st_q.acc), .b(~opnd_d), .sum(sub_d)
    );
    oc_cntcmp #(.WIDTH(WIDTH)) u_ccs (
        .opnd(opnd_d), .dim(dim_d), .skip(ccs_skip_d)
    );
    oc_store_fix #(.WIDTH(WIDTH)) u_fix (
        .acc(st_q.acc), .wword(stw_d), .acc_fix(fix_d), .ovf(ovf_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = op_valid;
        st_d.we   = 1'b0;
        st_d.skip = '0;
        if (op_valid) begin
            case (op_e'(op_code))
                OP_CNTCMP: begin
                    st_d.acc  = dim_d;
                    st_d.skip = ccs_skip_d;
                end
                OP_STORE: begin
                    st_d.we    = 1'b1;
                    st_d.wdata = stw_d;
                    st_d.acc   = fix_d;
                    st_d.skip  = {1'b0, ovf_d};
                end
                OP_ADD:     st_d.acc = add_d;
                OP_SUB:     st_d.acc = sub_d;
                OP_NEGLOAD: st_d.acc = ~opnd_d;
                OP_SWAP: begin
                    st_d.acc   = opnd_d;
                    st_d.we    = !mem_ro;
                    st_d.wdata = stw_d;
                end
                OP_AND:     st_d.acc = opnd_d & st_q.acc;
                default:    st_d.acc = st_q.acc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_out   = st_q.acc;
    assign wr_data   = st_q.wdata;
    assign wr_en     = st_q.we;
    assign skip_cnt  = st_q.skip;
    assign res_valid = st_q.vld;
endmodule

// File: rtl/oc_accum_unit_chk.sv
module oc_accum_unit_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [WIDTH-2:0] mem_rdata,
    input logic             mem_ro,
    input logic [WIDTH-1:0] acc_out,
    input logic [WIDTH-2:0] wr_data,
    input logic             wr_en,
    input logic [1:0]       skip_cnt,
    input logic             res_valid
);
    localparam int TOP = WIDTH - 1;
    localparam int OVB = WIDTH - 2;
    localparam logic [WIDTH-1:0] PLUS1  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] MINUS1 = {{(WIDTH-1){1'b1}}, 1'b0};

    // R4: plus zero operand
    a_r4_plus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0 && mem_rdata == '0)
        |=> (skip_cnt == 2'd1 && acc_out == '0));

    // R4: minus zero operand
    a_r4_minus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0 && mem_rdata == '1)
        |=> (skip_cnt == 2'd3 && acc_out == '0));

    // R5: store without overflow
    a_r5_store_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1 && acc_out[TOP] == acc_out[OVB])
        |=> (wr_en && skip_cnt == 2'd0 && acc_out == $past(acc_out)
             && wr_data == $past(acc_out[OVB:0])));

    // R6: store with overflow
    a_r6_store_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1 && acc_out[TOP] != acc_out[OVB])
        |=> (wr_en && skip_cnt == 2'd1 && (acc_out == PLUS1 || acc_out == MINUS1)));

    // R9: read-only exchange target is never written
    a_r9_ro_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5 && mem_ro) |=> !wr_en);

    // R10: idle cycle yields quiet outputs and a held accumulator
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !wr_en && skip_cnt == 2'd0
                       && acc_out == $past(acc_out)));
endmodule

bind oc_accum_unit oc_accum_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .mem_rdata(mem_rdata), .mem_ro(mem_ro), .acc_out(acc_out),
    .wr_data(wr_data), .wr_en(wr_en), .skip_cnt(skip_cnt),
    .res_valid(res_valid)
);

// File: tb/sim_oc_accum_unit.sv
`timescale 1ns/1ps
module sim_oc_accum_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [14:0] mem_rdata = '0;
    logic        mem_ro = 1'b0;
    logic [15:0] acc_out;
    logic [14:0] wr_data;
    logic        wr_en;
    logic [1:0]  skip_cnt;
    logic        res_valid;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [15:0] m_acc = '0;

    always #2.5 clk = ~clk;

    oc_accum_unit #(.WIDTH(16)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .mem_rdata(mem_rdata), .mem_ro(mem_ro), .acc_out(acc_out),
        .wr_data(wr_data), .wr_en(wr_en), .skip_cnt(skip_cnt),
        .res_valid(res_valid)
    );

    function automatic string tag_of(input logic v, input logic [2:0] c);
        if (!v) return "R10";
        case (c)
            3'd0: return "R3/R4";
            3'd1: return "R5/R6";
            3'd2, 3'd3: return "R7";
            3'd4, 3'd6: return "R8";
            3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s > 65535) s = s - 65536 + 1;
        return s[15:0];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive at a negedge, compare at the next negedge
    task automatic step(input logic v, input logic [2:0] c,
                        input logic [14:0] m, input logic ro);
        logic [15:0] x, e_acc;
        logic [14:0] e_wd;
        logic        e_we;
        logic [1:0]  e_sk;
        string       t;
        op_valid = v; op_code = c; mem_rdata = m; mem_ro = ro;
        x = {m[14], m};
        e_acc = m_acc; e_we = 1'b0; e_wd = '0; e_sk = 2'd0;
        if (v) begin
            case (c)
                3'd0: begin
                    if (x == 16'h0000)      begin e_acc = 0; e_sk = 1; end
                    else if (x == 16'hFFFF) begin e_acc = 0; e_sk = 3; end
                    else if (x[15] == 0)    begin e_acc = x - 1; e_sk = 0; end
                    else                    begin e_acc = ~x - 1; e_sk = 2; end
                end
                3'd1: begin
                    e_we = 1;
                    if (m_acc[15] != m_acc[14]) begin
                        e_wd = {m_acc[15], m_acc[13:0]};
                        e_acc = m_acc[15] ? 16'hFFFE : 16'h0001;
                        e_sk = 1;
                    end else begin
                        e_wd = m_acc[14:0];
                    end
                end
                3'd2: e_acc = oc_add(m_acc, x);
                3'd3: e_acc = oc_add(m_acc, ~x);
                3'd4: e_acc = ~x;
                3'd5: begin
                    e_acc = x; e_we = !ro;
                    e_wd = {m_acc[15], m_acc[13:0]};
                end
                3'd6: e_acc = x & m_acc;
                default: ;
            endcase
        end
        t = tag_of(v, c);
        @(negedge clk);
        check(t, "acc", acc_out, e_acc);
        check(t, "wr_en", {15'd0, wr_en}, {15'd0, e_we});
        if (e_we) check(t, "wr_data", {1'b0, wr_data}, {1'b0, e_wd});
        check(t, "skip", {14'd0, skip_cnt}, {14'd0, e_sk});
        check("R10", "res_valid", {15'd0, res_valid}, {15'd0, v});
        m_acc = e_acc;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "acc", acc_out, 16'h0000);
        check("R1", "wr_en", {15'd0, wr_en}, 16'd0);
        check("R1", "skip", {14'd0, skip_cnt}, 16'd0);
        check("R1", "res_valid", {15'd0, res_valid}, 16'd0);

        // R3/R4: each count-compare class
        step(1, 3'd0, 15'h0005, 0);   // positive -> 4, skip 0
        step(1, 3'd0, 15'h0001, 0);   // positive one -> plus zero
        step(1, 3'd0, 15'h0000, 0);   // plus zero -> skip 1
        step(1, 3'd0, 15'h7FFA, 0);   // negative -> 4, skip 2
        step(1, 3'd0, 15'h7FFF, 0);   // minus zero -> skip 3
        // R2: sign widening via exchange load
        step(1, 3'd5, 15'h4123, 1);
        check("R2", "acc sign copy", {15'd0, acc_out[15]}, 16'd1);
        // R5: store without overflow
        step(1, 3'd4, 15'h7FF0, 0);   // acc = 0x000F
        step(1, 3'd1, 15'h0000, 0);
        // R6: positive overflow then store
        step(1, 3'd4, 15'h7FFF, 0);   // acc = 0
        step(1, 3'd2, 15'h3FFF, 0);
        step(1, 3'd2, 15'h3FFF, 0);   // 0x7FFE overflow
        step(1, 3'd1, 15'h0000, 0);   // acc=1, skip 1
        // R6: negative overflow then store
        step(1, 3'd4, 15'h3FFF, 0);   // acc = 0xC000
        step(1, 3'd2, 15'h4000, 0);   // 0x8001
        step(1, 3'd1, 15'h0000, 0);   // acc=0xFFFE, skip 1
        // R7: overflow returning to range, subtract, end-around
        step(1, 3'd4, 15'h7FFF, 0);
        step(1, 3'd2, 15'h3FFF, 0);
        step(1, 3'd2, 15'h3FFF, 0);
        step(1, 3'd3, 15'h3FFF, 0);
        step(1, 3'd2, 15'h7FFE, 0);
        // R8: AND and complementing load
        step(1, 3'd4, 15'h0F0F, 0);
        step(1, 3'd6, 15'h3333, 0);
        // R9: exchange both targets
        step(1, 3'd5, 15'h1234, 0);
        step(1, 3'd5, 15'h0777, 1);
        // R10: no-op code and idle
        step(1, 3'd7, 15'h5555, 0);
        step(0, 3'd1, 15'h5555, 0);
        step(0, 3'd5, 15'h0000, 0);

        for (int i = 0; i < 600; i++) begin
            logic [14:0] rm;
            rm = 15'($urandom);
            if (($urandom % 4) == 0)
                rm = (($urandom % 2) == 0) ? 15'h3FFF : 15'h4000;
            step(($urandom % 8) != 0, 3'($urandom), rm, 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule